// File: doc/BRIEF.md
# Single-Slope PWM Compare Generator

This block produces a pulse-width-modulated output from a free-running up-counter that steps through every value of its range once per period and then wraps to zero. An active compare value sets where inside the period the output edge falls. The output is set at the start of each period and cleared once the count has passed the compare value. With the default width of 8 bits the period is 256 clock ticks. A polarity input chooses between the plain waveform and its complement.

The duty mapping is offset by one. There are 256 compare codes and 257 possible duty levels, from 0/256 to 256/256, so each polarity loses one extreme. In non-inverting polarity, code C gives C+1 high ticks. Code 255 holds the output high, and a fully low output cannot be reached. In inverting polarity, code C gives 255−C high ticks. Code 255 holds the output low, and a fully high output cannot be reached. The host writes new codes through a strobe into a pending register. The active compare takes the pending value only at the period wrap, so every period runs with a single compare value.

The output path is a three-state machine. `OS_IDLE` is the state after reset, and the output is low in it. `OS_ON` is the leading phase of the period. `OS_OFF` is the trailing phase after the compare match. The transitions are:
- idle→on at the first wrap;
- on→off at the enabled cycle where the count equals the active compare;
- off→on at a wrap;
- on→on at a wrap.

The output in `OS_ON` is high in non-inverting polarity and low in inverting polarity. `OS_OFF` gives the opposite level.

Top module: `pwm_fast_unit`

## Requirements
- R1: While enabled, the count advances by one each clock, runs 0 to 255 and wraps to 0, so a period is 256 ticks.
- R2: The wrap pulse is high in exactly those enabled cycles where the count is 255, which gives one pulse per period. The count is 0 in the following cycle.
- R3: With polarity 0 (non-inverting), the output is high in the cycles where the count is 0..C and low otherwise, which gives C+1 high ticks out of 256. C=0 gives one high tick per period. C=255 keeps the output high with no low tick.
- R4: With polarity 1 (inverting), the output is the complement of R3 and gives 255−C high ticks. C=255 keeps the output low. C=0 gives 255 high ticks, so an all-high period never occurs.
- R5: A write strobe captures the data into the pending register. The active compare copies the pending register only at the edge that ends a count-255 enabled cycle. A write in the middle of a period does not change that period's duty. A write issued in the count-255 cycle takes effect one period later.
- R6: While enable is low, the count holds, the wrap pulse stays low and the output level and machine state hold. This assumes the polarity input is held constant.
- R7: Synchronous reset clears the count, the pending compare and the active compare to 0. It forces the output low in both polarities until the first wrap. The first full period after reset therefore runs with compare 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; low freezes the unit |
| cmp_wdata | input | 8 | Compare code to be written |
| cmp_wr | input | 1 | Write strobe for the pending compare register |
| mode_inv | input | 1 | Polarity: 0 non-inverting, 1 inverting |
| pwm_out | output | 1 | PWM output |
| count_out | output | 8 | Current counter value |
| wrap_pulse | output | 1 | One-cycle pulse in the cycle where the count is 255 |

## Verification
The assertions check the following on every cycle:
- the counter step and hold;
- that a wrap is followed by a zero count;
- that the active compare changes only at a wrap;
- that every wrap enters the leading phase;
- that the output stays fixed when code 255 is active in either polarity.

Only the bench scenarios can show the behaviour that spans a whole period. This covers the exact high-tick totals for codes 0, 255 and random values in both polarities. It also covers the one-period delay of writes made mid-period or in the wrap cycle, the low output before the first wrap after reset, and the compare value of 0 that reset leaves behind.

// File: rtl/pwm_fast_pkg.sv
package pwm_fast_pkg;

    typedef enum logic [1:0] {
        OS_IDLE = 2'd0,
        OS_ON   = 2'd1,
        OS_OFF  = 2'd2
    } out_state_e;

    typedef enum logic {
        POL_NONINV = 1'b0,
        POL_INV    = 1'b1
    } polarity_e;

endpackage

// File: rtl/pwm_fast_counter.sv
module pwm_fast_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + 1'b1;
        end
    end

    // The wrap happens in the enabled cycle that sits at the top of the range.
    assign wrap = en && (cnt == TOP);

    a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
        en |=> cnt == CNT_W'($past(cnt) + 1'b1));

    a_r6_count_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(cnt));

endmodule

// File: rtl/pwm_fast_cmpbuf.sv
module pwm_fast_cmpbuf #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             wrap,
    output logic [CNT_W-1:0] active
);
    logic [CNT_W-1:0] pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= '0;
            active  <= '0;
        end else begin
            if (wr) begin
                pending <= wdata;
            end
            // The active code copies the older pending value, so a write in the wrap cycle waits a period.
            if (wrap) begin
                active <= pending;
            end
        end
    end

    a_r5_active_only_at_wrap: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(active));

endmodule

// File: rtl/pwm_fast_outfsm.sv
module pwm_fast_outfsm
    import pwm_fast_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] active,
    input  logic             mode_inv,
    output logic             pwm
);
    localparam logic [CNT_W-1:0] TOP = '1;

    out_state_e state;
    out_state_e state_nxt;
    polarity_e  pol;

    assign pol = polarity_e'(mode_inv);

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= OS_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            OS_IDLE: begin
                if (wrap) state_nxt = OS_ON;
            end
            OS_ON: begin
                if (wrap) begin
                    state_nxt = OS_ON;
                end else if (en && (cnt == active)) begin
                    state_nxt = OS_OFF;
                end
            end
            OS_OFF: begin
                if (wrap) state_nxt = OS_ON;
            end
            default: state_nxt = OS_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        pwm = 1'b0;
        unique case (state)
            OS_IDLE: pwm = 1'b0;
            OS_ON:   pwm = (pol == POL_NONINV);
            OS_OFF:  pwm = (pol == POL_INV);
            default: pwm = 1'b0;
        endcase
    end

    a_r3_wrap_enters_on: assert property (@(posedge clk) disable iff (rst)
        wrap |=> state == OS_ON);

    a_r3_top_code_full_on: assert property (@(posedge clk) disable iff (rst)
        (state != OS_IDLE && active == TOP && !mode_inv) |-> pwm);

    a_r4_top_code_full_off: assert property (@(posedge clk) disable iff (rst)
        (active == TOP && mode_inv) |-> !pwm);

    a_r6_state_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(state));

endmodule

// File: rtl/pwm_fast_unit.sv
module pwm_fast_unit #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             cmp_wr,
    input  logic             mode_inv,
    output logic             pwm_out,
    output logic [CNT_W-1:0] count_out,
    output logic             wrap_pulse
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] active;
    logic             wrap;

    pwm_fast_counter #(.CNT_W(CNT_W)) u_counter (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .cnt  (cnt),
        .wrap (wrap)
    );

    pwm_fast_cmpbuf #(.CNT_W(CNT_W)) u_cmpbuf (
        .clk    (clk),
        .rst    (rst),
        .wr     (cmp_wr),
        .wdata  (cmp_wdata),
        .wrap   (wrap),
        .active (active)
    );

    pwm_fast_outfsm #(.CNT_W(CNT_W)) u_outfsm (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .wrap     (wrap),
        .cnt      (cnt),
        .active   (active),
        .mode_inv (mode_inv),
        .pwm      (pwm_out)
    );

    assign count_out  = cnt;
    assign wrap_pulse = wrap;

    a_r2_wrap_then_zero: assert property (@(posedge clk) disable iff (rst)
        wrap_pulse |=> count_out == '0);

endmodule

// File: tb/pwm_fast_unit_bench.sv
`timescale 1ns/1ps
module pwm_fast_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [7:0] cmp_wdata = 8'd0;
    logic       cmp_wr = 1'b0;
    logic       mode_inv = 1'b0;
    logic       pwm_out;
    logic [7:0] count_out;
    logic       wrap_pulse;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pwm_fast_unit u_pwm_fast_unit (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .cmp_wdata  (cmp_wdata),
        .cmp_wr     (cmp_wr),
        .mode_inv   (mode_inv),
        .pwm_out    (pwm_out),
        .count_out  (count_out),
        .wrap_pulse (wrap_pulse)
    );

    function automatic int exp_high(input int code, input bit inv);
        return inv ? (255 - code) : (code + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic write_cmp(input int v);
        cmp_wr = 1'b1;
        cmp_wdata = 8'(v);
        tick();
        cmp_wr = 1'b0;
    endtask

    task automatic align;
        tick();
        while (count_out != 8'd0) tick();
    endtask

    // Measures one period starting at count 0; optionally writes a code at tick wr_at.
    task automatic measure(input int wr_at, input int wr_val, output int highs);
        int wraps = 0;
        bit seq_ok = 1'b1;
        bit wrap_ok = 1'b1;
        highs = 0;
        for (int k = 0; k < 256; k++) begin
            if (pwm_out) highs++;
            if (wrap_pulse) wraps++;
            if (int'(count_out) != k) seq_ok = 1'b0;
            if (wrap_pulse != (count_out == 8'd255)) wrap_ok = 1'b0;
            if (k == wr_at) begin
                cmp_wr = 1'b1;
                cmp_wdata = 8'(wr_val);
            end
            tick();
            cmp_wr = 1'b0;
        end
        check(seq_ok, "R1 count sequence", int'(seq_ok), 1);
        check(wrap_ok && wraps == 1, "R2 wrap pulses per period", wraps, 1);
    endtask

    task automatic duty_case(input int code, input bit inv, input string req);
        int h;
        mode_inv = inv;
        write_cmp(code);
        align();
        measure(-1, 0, h);
        check(h == exp_high(code, inv), req, h, exp_high(code, inv));
    endtask

    initial begin
        int h;
        int v1;
        int v2;
        int v3;
        bit low_ok;
        void'($urandom(32'd4711));
        repeat (4) tick();
        // R7: reset state
        check(count_out == 8'd0 && !pwm_out && !wrap_pulse, "R7 reset outputs",
              int'(count_out) + int'(pwm_out) + int'(wrap_pulse), 0);
        rst = 1'b0;
        en = 1'b1;
        mode_inv = 1'b1;
        low_ok = 1'b1;
        while (count_out != 8'd255) begin
            if (pwm_out) low_ok = 1'b0;
            tick();
        end
        if (pwm_out) low_ok = 1'b0;
        tick();
        check(low_ok, "R7 output low before first wrap in inverting polarity", int'(!low_ok), 0);
        measure(-1, 0, h);
        check(h == 255, "R7 first period uses cleared compare (inverting)", h, 255);

        // Directed corner codes
        duty_case(0,   1'b0, "R3 code 0 gives one high tick");
        duty_case(255, 1'b0, "R3 code 255 stays high");
        duty_case(255, 1'b1, "R4 code 255 stays low");
        duty_case(0,   1'b1, "R4 code 0 gives 255 high ticks");
        duty_case(128, 1'b0, "R3 mid code");

        // Random codes and polarities
        for (int i = 0; i < 12; i++) begin
            int c;
            bit p;
            c = int'($urandom_range(255, 0));
            p = 1'($urandom_range(1, 0));
            duty_case(c, p, p ? "R4 random code" : "R3 random code");
        end

        // R5: write in the middle of a period
        mode_inv = 1'b0;
        v1 = 40;
        v2 = 200;
        write_cmp(v1);
        align();
        measure(100, v2, h);
        check(h == v1 + 1, "R5 mid-period write leaves current duty", h, v1 + 1);
        measure(-1, 0, h);
        check(h == v2 + 1, "R5 new code applies next period", h, v2 + 1);

        // R5: write issued in the count-255 cycle
        v3 = 7;
        while (count_out != 8'd255) tick();
        write_cmp(v3);
        measure(-1, 0, h);
        check(h == v2 + 1, "R5 write at wrap delayed one period", h, v2 + 1);
        measure(-1, 0, h);
        check(h == v3 + 1, "R5 write at wrap then applies", h, v3 + 1);

        // R6: enable low mid-period and at the top of the range
        while (count_out != 8'd3) tick();
        begin
            logic [7:0] c0;
            logic p0;
            bit hold_ok = 1'b1;
            c0 = count_out;
            p0 = pwm_out;
            en = 1'b0;
            for (int k = 0; k < 10; k++) begin
                tick();
                if (count_out != c0 || pwm_out != p0 || wrap_pulse) hold_ok = 1'b0;
            end
            en = 1'b1;
            check(hold_ok, "R6 hold while disabled mid-period", int'(count_out), int'(c0));
        end
        while (count_out != 8'd254) tick();
        begin
            bit hold_ok = 1'b1;
            logic p0;
            tick();
            en = 1'b0;
            #0;
            p0 = pwm_out;
            if (wrap_pulse) hold_ok = 1'b0;
            for (int k = 0; k < 10; k++) begin
                tick();
                if (count_out != 8'd255 || wrap_pulse || pwm_out != p0) hold_ok = 1'b0;
            end
            en = 1'b1;
            check(hold_ok, "R6 hold at count 255 without wrap", int'(count_out), 255);
            tick();
            check(count_out == 8'd0, "R1 wrap after resume", int'(count_out), 0);
        end

        // R7: reset mid-run clears both compare registers
        write_cmp(90);
        while (count_out != 8'd255) tick();
        write_cmp(90);
        while (count_out != 8'd60) tick();
        mode_inv = 1'b0;
        rst = 1'b1;
        tick();
        tick();
        check(count_out == 8'd0 && !pwm_out, "R7 reset mid-run", int'(count_out), 0);
        rst = 1'b0;
        low_ok = 1'b1;
        while (count_out != 8'd255) begin
            if (pwm_out) low_ok = 1'b0;
            tick();
        end
        tick();
        check(low_ok, "R7 output low before first wrap in non-inverting polarity", int'(!low_ok), 0);
        measure(-1, 0, h);
        check(h == 1, "R7 compare cleared by reset", h, 1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule